// File: doc/BRIEF.md
# Four-Lane Time-Interleaved ALU

This block keeps a full-rate stream of 16-bit ALU operations flowing while every arithmetic copy inside it gets four clock periods to settle. It holds four identical combinational ALU lanes, each behind its own operand register. A free-running 2-bit phase counter gives each lane one load slot in every four clocks, so the operations accepted on consecutive clocks land in lanes 0, 1, 2, 3 and then wrap back to lane 0.

A rotating 4-to-1 selector, driven by the same counter, picks the lane whose four-cycle window is about to end. A full-rate output register captures that lane's result and flags. The block accepts one operation per clock, delivers one result per clock in issue order, and has a fixed latency. A valid bit travels with each operation, so idle slots leave as idle slots.

Top module: `interleaved_alu`

## Requirements
- R1: While `rst_n` is low at a clock edge, the output register clears: `out_valid`, `out_result`, `out_cout`, `out_zero` and `out_cmp` are all 0 after that edge.
- R2: Arithmetic. Opcode 4'b0000 gives `{out_cout,out_result} = a + b + cin`. Opcode 4'b0001 gives `out_result = (a - b - cin) mod 2^16`, with `out_cout` set to 1 when that subtraction borrows.
- R3: Bitwise operations. Opcode 4'b0100 gives `a ^ b`. Opcode 4'b0101 gives `~(a | b)`. Opcode 4'b0110 gives `a | b`. Opcode 4'b0111 gives `a & b`. Opcode 4'b1010 gives `~(a & b)`. For all of them `out_cout` and `out_cmp` are 0.
- R4: Comparisons. Opcode 4'b0010 sets `out_cmp` to `(a == b)`. Opcode 4'b0011 sets `out_cmp` to `(a != b)`. For both, `out_result` and `out_cout` are 0. For every other opcode `out_cmp` is 0.
- R5: Opcode 4'b1000 passes `a` through and opcode 4'b1001 passes `b` through. Opcodes 4'b1011 to 4'b1111 give an all-zero result with all flags 0, except `out_zero`, which is 1.
- R6: `out_zero` is 1 exactly when `out_result` is 0, for every valid result.
- R7: An operation presented with `in_valid` high before clock edge k appears on the outputs right after edge k+4 (latency 5 clocks). One operation is accepted every clock, and results leave in issue order.
- R8: `out_valid` is high only in slots whose operation was presented with `in_valid` high. A bubble on the input produces a bubble on the output exactly 5 clocks later.
- R9: After reset is released, `out_valid` stays low until the first issued operation reaches the output register. The first four post-reset edges never produce a valid result.
- R10: The lane load enables are one-hot, and they advance by one lane every clock, wrapping from the last lane to lane 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock; all registers use the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operation present in this slot |
| in_a | input | 16 | First operand |
| in_b | input | 16 | Second operand |
| in_op | input | 4 | Operation code |
| in_cin | input | 1 | Carry / borrow input |
| out_valid | output | 1 | Result present in this slot |
| out_result | output | 16 | Result word |
| out_cout | output | 1 | Carry-out (add) or borrow (subtract) |
| out_zero | output | 1 | Result is zero |
| out_cmp | output | 1 | Comparison outcome |

## Verification
If the phase counter and the selector fall out of step, a lane's result is taken either before its operand register reloads or a clock late. Either way the stream at the port shows values belonging to the neighbouring issue slot. Because the bench issues a distinct operation on every clock, that mismatch appears within the first five clocks after the first valid issue. A lost or misrouted valid bit shows up as a missing or spurious `out_valid`, exactly five clocks after the affected input slot. A wrong opcode decode shows up on the first vector that uses that opcode.

// File: rtl/alu_pkg.sv
// Shared constants for the interleaved ALU: opcode width and opcode values.
// Assumes a 4-bit opcode field; codes not listed decode to an all-zero result.
package alu_pkg;
    localparam int OP_W = 4;

    localparam logic [OP_W-1:0] OP_ADD   = 4'b0000;
    localparam logic [OP_W-1:0] OP_SUB   = 4'b0001;
    localparam logic [OP_W-1:0] OP_EQ    = 4'b0010;
    localparam logic [OP_W-1:0] OP_NE    = 4'b0011;
    localparam logic [OP_W-1:0] OP_XOR   = 4'b0100;
    localparam logic [OP_W-1:0] OP_NOR   = 4'b0101;
    localparam logic [OP_W-1:0] OP_OR    = 4'b0110;
    localparam logic [OP_W-1:0] OP_AND   = 4'b0111;
    localparam logic [OP_W-1:0] OP_PASSA = 4'b1000;
    localparam logic [OP_W-1:0] OP_PASSB = 4'b1001;
    localparam logic [OP_W-1:0] OP_NAND  = 4'b1010;
endpackage

// File: rtl/alu_core.sv
// Combinational ALU lane. It turns one registered operation into a result word
// and three flags. It assumes its inputs hold steady for the whole lane window.
module alu_core
    import alu_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic [OP_W-1:0]  op,
    input  logic             cin,
    output logic [WIDTH-1:0] res,
    output logic             cout,
    output logic             zero,
    output logic             cmp
);
    logic [WIDTH:0] sum_w;
    logic [WIDTH:0] dif_w;

    // Wide add and subtract; bit WIDTH carries the carry or the borrow.
    always_comb begin
        sum_w = {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin};
        dif_w = {1'b0, a} - {1'b0, b} - {{WIDTH{1'b0}}, cin};
    end

    // Opcode decode into result and flags.
    always_comb begin
        res  = '0;
        cout = 1'b0;
        cmp  = 1'b0;
        case (op)
            OP_ADD:   begin res = sum_w[WIDTH-1:0]; cout = sum_w[WIDTH]; end
            OP_SUB:   begin res = dif_w[WIDTH-1:0]; cout = dif_w[WIDTH]; end
            OP_EQ:    cmp = (a == b);
            OP_NE:    cmp = (a != b);
            OP_XOR:   res = a ^ b;
            OP_NOR:   res = ~(a | b);
            OP_OR:    res = a | b;
            OP_AND:   res = a & b;
            OP_PASSA: res = a;
            OP_PASSB: res = b;
            OP_NAND:  res = ~(a & b);
            default:  res = '0;
        endcase
        zero = (res == '0);
    end
endmodule

// File: rtl/lane_reg.sv
// Operand register for one lane. It loads only in its own phase slot and holds
// otherwise. It assumes the phase generator asserts its load for one clock in every LANES.
module lane_reg #(
    parameter int DW = 38
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] d,
    output logic [DW-1:0] q
);
    // Clear on reset; capture the incoming operation in this lane's slot.
    always_ff @(posedge clk) begin
        if (!rst_n)    q <= '0;
        else if (load) q <= d;
    end
endmodule

// File: rtl/phase_gen.sv
// Phase generator. A free-running counter yields the output selector and one
// one-hot load enable per lane. It assumes LANES is a power of two, at least 2.
module phase_gen #(
    parameter int LANES = 4,
    localparam int SEL_W = $clog2(LANES)
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [SEL_W-1:0] sel,
    output logic [LANES-1:0] lane_en
);
    // Count slots; wraps naturally because LANES is a power of two.
    always_ff @(posedge clk) begin
        if (!rst_n) sel <= '0;
        else        sel <= sel + 1'b1;
    end

    // Decode the count into one enable per lane.
    for (genvar g = 0; g < LANES; g++) begin : g_en
        assign lane_en[g] = (sel == g[SEL_W-1:0]);
    end
endmodule

// File: rtl/interleaved_alu.sv
// Top of the interleaved ALU. Issue slots are spread round-robin over LANES
// operand registers, each feeding its own combinational ALU. A selector that
// follows the same counter picks the lane about to reload, and a full-rate
// output register captures it. Latency is LANES+1 clocks from presentation.
module interleaved_alu
    import alu_pkg::*;
#(
    parameter int WIDTH = 16,
    parameter int LANES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [WIDTH-1:0] in_a,
    input  logic [WIDTH-1:0] in_b,
    input  logic [OP_W-1:0]  in_op,
    input  logic             in_cin,
    output logic             out_valid,
    output logic [WIDTH-1:0] out_result,
    output logic             out_cout,
    output logic             out_zero,
    output logic             out_cmp
);
    localparam int SEL_W = $clog2(LANES);
    localparam int DW    = 2 * WIDTH + OP_W + 2;

    logic [SEL_W-1:0] sel;
    logic [LANES-1:0] lane_en;
    logic [DW-1:0]    pack_in;
    logic [DW-1:0]    lane_q   [LANES];
    logic [WIDTH-1:0] lane_res [LANES];
    logic             lane_vld [LANES];
    logic             lane_co  [LANES];
    logic             lane_z   [LANES];
    logic             lane_cmp [LANES];

    phase_gen #(.LANES(LANES)) u_phase (
        .clk(clk), .rst_n(rst_n), .sel(sel), .lane_en(lane_en)
    );

    assign pack_in = {in_valid, in_cin, in_op, in_a, in_b};

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        lane_reg #(.DW(DW)) u_reg (
            .clk(clk), .rst_n(rst_n), .load(lane_en[g]),
            .d(pack_in), .q(lane_q[g])
        );
        alu_core #(.WIDTH(WIDTH)) u_alu (
            .a   (lane_q[g][2*WIDTH-1:WIDTH]),
            .b   (lane_q[g][WIDTH-1:0]),
            .op  (lane_q[g][2*WIDTH+OP_W-1:2*WIDTH]),
            .cin (lane_q[g][2*WIDTH+OP_W]),
            .res (lane_res[g]),
            .cout(lane_co[g]),
            .zero(lane_z[g]),
            .cmp (lane_cmp[g])
        );
        assign lane_vld[g] = lane_q[g][DW-1];
    end

    // Capture the lane whose window closes in this slot; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_result <= '0;
            out_cout   <= 1'b0;
            out_zero   <= 1'b0;
            out_cmp    <= 1'b0;
        end else begin
            out_valid  <= lane_vld[sel];
            out_result <= lane_res[sel];
            out_cout   <= lane_co[sel];
            out_zero   <= lane_z[sel];
            out_cmp    <= lane_cmp[sel];
        end
    end
endmodule

// File: rtl/interleaved_alu_checker.sv
// Property checker for interleaved_alu. It counts clocks since reset so that no
// past value reaches back across reset. It is attached to every instance by bind.
module interleaved_alu_checker
    import alu_pkg::*;
#(
    parameter int WIDTH = 16,
    parameter int LANES = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [WIDTH-1:0] in_a,
    input logic [OP_W-1:0]  in_op,
    input logic             out_valid,
    input logic [WIDTH-1:0] out_result,
    input logic             out_zero,
    input logic [LANES-1:0] lane_en
);
    localparam int LAT = LANES + 1;

    logic [7:0]       since_rst;
    logic [LANES-1:0] en_prev;

    // Saturating count of clocks since reset release, plus last enable pattern.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_rst <= '0;
            en_prev   <= '0;
        end else begin
            if (since_rst != 8'hFF) since_rst <= since_rst + 1'b1;
            en_prev <= lane_en;
        end
    end

    // R10: exactly one lane loads per clock.
    a_r10_onehot_load: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(lane_en) == 1);

    // R10: the load slot advances by one lane each clock.
    a_r10_rotate: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 8'd1) |->
        lane_en == {en_prev[LANES-2:0], en_prev[LANES-1]});

    // R9: no valid result before the first operation can arrive.
    a_r9_no_early_valid: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (since_rst >= 8'(LAT)));

    // R7, R8: the output valid follows the input valid five clocks later.
    a_r8_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 8'(LAT)) |-> (out_valid == $past(in_valid, 5)));

    // R5, R7: a pass-through of operand A reappears five clocks later.
    a_r5_pass_a: assert property (@(posedge clk) disable iff (!rst_n)
        ((since_rst >= 8'(LAT)) && out_valid && ($past(in_op, 5) == OP_PASSA))
        |-> (out_result == $past(in_a, 5)));

    // R6: the zero flag agrees with the result word.
    a_r6_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_zero == (out_result == '0)));
endmodule

bind interleaved_alu interleaved_alu_checker #(.WIDTH(WIDTH), .LANES(LANES)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_a(in_a), .in_op(in_op),
    .out_valid(out_valid), .out_result(out_result), .out_zero(out_zero),
    .lane_en(lane_en)
);

// File: tb/interleaved_alu_test.sv
// Streaming sweep: every opcode against both carry inputs and a mix of corner
// and pseudo-random operands, with periodic bubbles. Expected results are worked
// out arithmetically and compared five clocks after issue.
module interleaved_alu_test;
    localparam int W    = 16;
    localparam int NVEC = 2048;
    localparam int LAT  = 5;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          in_valid;
    logic [W-1:0]  in_a, in_b;
    logic [3:0]    in_op;
    logic          in_cin;
    logic          out_valid, out_cout, out_zero, out_cmp;
    logic [W-1:0]  out_result;

    int checks = 0;
    int fails  = 0;

    logic          e_v   [NVEC + LAT];
    logic [W-1:0]  e_r   [NVEC + LAT];
    logic          e_c   [NVEC + LAT];
    logic          e_z   [NVEC + LAT];
    logic          e_k   [NVEC + LAT];
    logic [3:0]    e_op  [NVEC + LAT];

    always #2 clk = ~clk;

    interleaved_alu uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
        .in_op(in_op), .in_cin(in_cin), .out_valid(out_valid),
        .out_result(out_result), .out_cout(out_cout), .out_zero(out_zero),
        .out_cmp(out_cmp)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Expected-value model built from the requirement text.
    task automatic model(input logic [3:0] op, input logic [W-1:0] a, input logic [W-1:0] b,
                         input logic ci, output logic [W-1:0] r, output logic co,
                         output logic k);
        int ia, ib, t;
        ia = int'(a); ib = int'(b);
        r = '0; co = 1'b0; k = 1'b0;
        case (op)
            4'd0: begin t = ia + ib + int'(ci); r = t[W-1:0]; co = (t >= 65536); end
            4'd1: begin t = ia - ib - int'(ci); r = t[W-1:0]; co = (t < 0); end
            4'd2: k = (ia == ib);
            4'd3: k = (ia != ib);
            4'd4: r = a ^ b;
            4'd5: r = ~(a | b);
            4'd6: r = a | b;
            4'd7: r = a & b;
            4'd8: r = a;
            4'd9: r = b;
            4'd10: r = ~(a & b);
            default: r = '0;
        endcase
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin : stim
        logic [15:0] lfsr;
        rst_n = 1'b0; in_valid = 1'b0; in_a = '0; in_b = '0; in_op = '0; in_cin = 1'b0;
        lfsr = 16'hACE1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: output register cleared while reset is held.
        check("R1 valid", {31'b0, out_valid}, 0);
        check("R1 result", {16'b0, out_result}, 0);
        check("R1 flags", {29'b0, out_cout, out_zero, out_cmp}, 0);
        rst_n = 1'b1;
        for (int i = 0; i < NVEC + LAT; i++) begin
            // Check the slot issued LAT clocks ago (R7 ordering and latency).
            if (i >= LAT) begin
                int j;
                j = i - LAT;
                check("R8 valid", {31'b0, out_valid}, {31'b0, e_v[j]});
                if (e_v[j]) begin
                    case (e_op[j])
                        4'd0, 4'd1: check("R2 arith", {15'b0, out_cout, out_result}, {15'b0, e_c[j], e_r[j]});
                        4'd2, 4'd3: check("R4 compare", {15'b0, out_cmp, out_result}, {15'b0, e_k[j], e_r[j]});
                        4'd8, 4'd9: check("R5 pass", {16'b0, out_result}, {16'b0, e_r[j]});
                        4'd4, 4'd5, 4'd6, 4'd7, 4'd10:
                                    check("R3 logic", {14'b0, out_cout, out_cmp, out_result}, {16'b0, e_r[j]});
                        default:    check("R5 undefined", {14'b0, out_cout, out_cmp, out_result}, 0);
                    endcase
                    check("R7 flags", {29'b0, out_cout, out_zero, out_cmp}, {29'b0, e_c[j], e_z[j], e_k[j]});
                    check("R6 zero", {31'b0, out_zero}, {31'b0, e_r[j] == '0});
                end
            end else begin
                // R9: nothing valid during the first LAT post-reset slots.
                check("R9 early", {31'b0, out_valid}, 0);
            end
            // Drive the next slot.
            if (i < NVEC) begin
                logic [W-1:0] a, b, r;
                logic co, k;
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                a = lfsr;
                b = {lfsr[7:0], lfsr[15:8]} ^ 16'h5A3C;
                case ((i / 32) % 6)
                    0: begin a = 16'hFFFF; b = 16'h0001; end
                    1: b = a;
                    2: begin a = 16'h0000; b = 16'h0000; end
                    3: begin a = 16'h0001; b = 16'hFFFF; end
                    default: ;
                endcase
                in_valid = ((i % 7) != 6);
                in_op    = 4'(i % 16);
                in_cin   = (((i / 16) % 2) == 1);
                in_a     = a;
                in_b     = b;
                model(in_op, a, b, in_cin, r, co, k);
                e_v[i] = in_valid; e_r[i] = r; e_c[i] = co; e_k[i] = k;
                e_z[i] = (r == '0); e_op[i] = in_op;
            end else begin
                in_valid = 1'b0;
            end
            @(negedge clk);
        end
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule